// File: doc/BRIEF.md
# Programmable Counter Capture-Compare Array

The block is built around one 16-bit timebase counter that four independent channels share. Each channel holds a 16-bit capture/compare value and a six-bit mode word. A channel can do four things. It can latch the running count when a chosen edge arrives on its external input. It can raise its event flag when the count equals its stored value. It can toggle its output pin on that equality. In pulse-width mode it can drive its pin from an 8-bit duty comparison. A run bit starts and stops the counter. Hardware raises an overflow flag when the counter wraps.

Software reaches every register through a single-cycle register bus. Writes take effect at the clock edge. Reads are combinational from the address. Event flags and the overflow flag are set only by hardware and cleared only by software, by writing a one to the flag's bit. Each channel has its own enable that routes its flag onto one shared interrupt line. A separate enable does the same for the overflow flag.

Top module: `pca_array`

## Requirements
- R1: After reset the run bit (control register bit 0) is 0 and the counter holds its value. While the run bit is 1 the counter advances by one on every clock.
- R2: A running counter that steps from 0xFFFF to 0x0000 sets the overflow flag (status bit 4). The flag stays set until software writes a 1 to status bit 4.
- R3: Each channel input passes through two synchronizing flip-flops. A rising edge captures when mode bit 5 is set, and a falling edge captures when mode bit 4 is set. A capture loads the counter value into the channel's capture/compare register and sets the channel's flag. An edge whose polarity is not enabled leaves both the register and the flag unchanged.
- R4: A match is the run bit set while the counter equals the channel's capture/compare register. A match sets the channel flag only when mode bit 3 is set.
- R5: With mode bit 2 set and pulse-width mode off, the channel output toggles once on each match. A match does not toggle the output of a channel whose mode bit 2 is clear.
- R6: Writing 1 to status bit n (0..3) clears the flag of channel n. Writing 0 to a bit leaves it unchanged. If a hardware set and a software clear reach one flag in the same cycle, the flag ends up set.
- R7: irq_o is high when the overflow flag is set together with control bit 1, or when any channel flag is set together with that channel's mode bit 0.
- R8: With mode bit 1 set, the channel output is low while the counter's low byte is below the active duty value and high otherwise. The active duty value reloads from bits 7:0 of the capture/compare register only when the counter's low byte steps from 0xFF to 0x00.
- R9: Register addresses are fixed. Address 0 holds control, address 1 holds status, and address 2 holds the counter. A bus write to the counter takes priority over counting. Addresses 4+n hold the mode word of channel n, and addresses 8+n hold its capture/compare register. Every register reads back at its address.
- R10: After reset every register reads zero, and cex_o and irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i |
| cex_i | input | 4 | Per-channel capture inputs (asynchronous) |
| cex_o | output | 4 | Per-channel compare/toggle/PWM outputs |
| irq_o | output | 1 | Combined interrupt |

## Verification
The collision that matters is a hardware set of a channel flag from a match landing in the same cycle as a software write-one-to-clear of that flag. The bench runs the counter toward a known compare value and polls the count over the bus. It issues the clear in exactly the cycle whose count equals the compare value. It then judges the result by reading the status register, which must still show the flag set. A second, isolated clear must then empty the flag.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int ADDR_W = 4;

  // mode word, bit 5 down to bit 0
  typedef struct packed {
    logic capp;  // capture on rising edge
    logic capn;  // capture on falling edge
    logic mat;   // match sets flag
    logic tog;   // match toggles output
    logic pwm;   // pulse-width mode
    logic ecf;   // flag drives interrupt
  } mode_t;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_MODE = 4'd4;
  localparam logic [ADDR_W-1:0] A_CCR  = 4'd8;
endpackage

// File: rtl/pca_counter.sv
module pca_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             wrap;

  assign wrap = run_i && !load_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (load_i)     cnt_q <= load_val_i;
      else if (run_i) cnt_q <= cnt_q + 1'b1;
      // set wins over clear
      if (wrap)           ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R1
  hold_when_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q));
  // R2
  wrap_sets_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (ovf_q && cnt_q == '0));
  // R2
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q);
endmodule

// File: rtl/pca_channel.sv
module pca_channel
  import pca_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PWM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  mode_t            mode_i,
  input  logic             ccr_we_i,
  input  logic [CNT_W-1:0] ccr_wdata_i,
  input  logic             flag_clr_i,
  input  logic             cex_i,
  output logic [CNT_W-1:0] ccr_o,
  output logic             flag_o,
  output logic             cex_o
);
  localparam logic [PWM_W-1:0] LO_MAX = '1;

  logic [1:0]       sync_q;
  logic             prev_q;
  logic [CNT_W-1:0] ccr_q;
  logic [PWM_W-1:0] duty_q;
  logic             flag_q, tog_q;
  logic             rise, fall, cap_evt, match, tog_evt, flag_set, lo_wrap;

  assign rise     = sync_q[1] && !prev_q;
  assign fall     = !sync_q[1] && prev_q;
  assign cap_evt  = (rise && mode_i.capp) || (fall && mode_i.capn);
  assign match    = run_i && (cnt_i == ccr_q);
  assign tog_evt  = match && mode_i.tog && !mode_i.pwm;
  assign flag_set = cap_evt || (match && mode_i.mat);
  assign lo_wrap  = run_i && (cnt_i[PWM_W-1:0] == LO_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      ccr_q  <= '0;
      duty_q <= '0;
      flag_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], cex_i};
      prev_q <= sync_q[1];
      // capture beats a bus write
      if (cap_evt)       ccr_q <= cnt_i;
      else if (ccr_we_i) ccr_q <= ccr_wdata_i;
      if (lo_wrap)       duty_q <= ccr_q[PWM_W-1:0];
      if (flag_set)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      if (tog_evt)       tog_q <= !tog_q;
    end
  end

  assign ccr_o  = ccr_q;
  assign flag_o = flag_q;
  assign cex_o  = mode_i.pwm ? (cnt_i[PWM_W-1:0] >= duty_q) : tog_q;

  // R3
  capture_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> (ccr_q == $past(cnt_i)));
  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_set |=> flag_q);
  // R5
  toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tog_evt |=> (tog_q != $past(tog_q)));
  // R8
  duty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_wrap |=> $stable(duty_q));
endmodule

// File: rtl/pca_array.sv
module pca_array
  import pca_pkg::*;
#(
  parameter int NUM_MOD = 4,
  parameter int CNT_W   = 16,
  parameter int PWM_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic [NUM_MOD-1:0] cex_i,
  output logic [NUM_MOD-1:0] cex_o,
  output logic              irq_o
);
  localparam int MODE_W = $bits(mode_t);

  logic                run_q, ovf_ie_q;
  logic                wr_ctrl, wr_stat, wr_cnt;
  logic [CNT_W-1:0]    cnt;
  logic                ovf;
  mode_t               mode_q [NUM_MOD];
  logic [CNT_W-1:0]    ccr [NUM_MOD];
  logic [NUM_MOD-1:0]  flag, ecf;

  assign wr_ctrl = bus_we_i && (bus_addr_i == A_CTRL);
  assign wr_stat = bus_we_i && (bus_addr_i == A_STAT);
  assign wr_cnt  = bus_we_i && (bus_addr_i == A_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      ovf_ie_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q    <= bus_wdata_i[0];
      ovf_ie_q <= bus_wdata_i[1];
    end
  end

  pca_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .load_i     (wr_cnt),
    .load_val_i (bus_wdata_i),
    .ovf_clr_i  (wr_stat && bus_wdata_i[NUM_MOD]),
    .cnt_o      (cnt),
    .ovf_o      (ovf)
  );

  for (genvar g = 0; g < NUM_MOD; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(A_MODE + g);
    localparam logic [ADDR_W-1:0] CCR_A  = ADDR_W'(A_CCR + g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q[g] <= '0;
      else if (bus_we_i && bus_addr_i == MODE_A) mode_q[g] <= mode_t'(bus_wdata_i[MODE_W-1:0]);
    end

    assign ecf[g] = mode_q[g].ecf;

    pca_channel #(.CNT_W(CNT_W), .PWM_W(PWM_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run_q),
      .cnt_i       (cnt),
      .mode_i      (mode_q[g]),
      .ccr_we_i    (bus_we_i && bus_addr_i == CCR_A),
      .ccr_wdata_i (bus_wdata_i),
      .flag_clr_i  (wr_stat && bus_wdata_i[g]),
      .cex_i       (cex_i[g]),
      .ccr_o       (ccr[g]),
      .flag_o      (flag[g]),
      .cex_o       (cex_o[g])
    );
  end

  assign irq_o = (ovf && ovf_ie_q) || |(flag & ecf);

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CTRL:  bus_rdata_o[1:0] = {ovf_ie_q, run_q};
      A_STAT:  bus_rdata_o[NUM_MOD:0] = {ovf, flag};
      A_CNT:   bus_rdata_o = cnt;
      default: begin
        for (int i = 0; i < NUM_MOD; i++) begin
          if (bus_addr_i == ADDR_W'(A_MODE + i)) bus_rdata_o[MODE_W-1:0] = mode_q[i];
          if (bus_addr_i == ADDR_W'(A_CCR + i))  bus_rdata_o = ccr[i];
        end
      end
    endcase
  end

  // R7
  irq_needs_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ovf || (|flag)));
  // R10
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(rst_ni)) |-> (!irq_o && cex_o == '0));
endmodule

// File: tb/tb_pca_array.sv
`timescale 1ns/1ps
module tb_pca_array;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic [3:0]  cex_i = '0;
  logic [3:0]  cex_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = !clk_i;

  pca_array dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .cex_i(cex_i),
    .cex_o(cex_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr_i = a;
    #1;
    d = bus_rdata_o;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    @(negedge clk_i);
    rd(4'd0, v); chk("R10 ctrl", v, 16'h0);
    rd(4'd1, v); chk("R10 status", v, 16'h0);
    rd(4'd9, v); chk("R10 ccr1", v, 16'h0);
    chk("R10 cex_o", {12'h0, cex_o}, 16'h0);
    chk("R10 irq_o", {15'h0, irq_o}, 16'h0);
    repeat (5) @(negedge clk_i);
    rd(4'd2, v); chk("R1 hold while stopped", v, 16'h0);
  endtask

  task automatic t_run();
    logic [15:0] v;
    wr(4'd0, 16'h0001);
    rd(4'd2, v); chk("R1 count after start", v, 16'h0);
    repeat (10) @(negedge clk_i);
    rd(4'd2, v); chk("R1 count after 10", v, 16'd10);
    wr(4'd0, 16'h0000);
    rd(4'd2, v);
    repeat (4) @(negedge clk_i);
    begin logic [15:0] w; rd(4'd2, w); chk("R1 stop holds", w, v); end
  endtask

  task automatic t_ovf();
    logic [15:0] v;
    wr(4'd0, 16'h0003);
    wr(4'd2, 16'hFFFD);
    rd(4'd2, v); chk("R9 counter load", v, 16'hFFFD);
    rd(4'd1, v); chk("R2 no ovf yet", v, 16'h0);
    repeat (3) @(negedge clk_i);
    rd(4'd2, v); chk("R2 wrapped to zero", v, 16'h0);
    rd(4'd1, v); chk("R2 ovf set", v, 16'h0010);
    chk("R7 irq from ovf", {15'h0, irq_o}, 16'h1);
    wr(4'd1, 16'h000F);
    rd(4'd1, v); chk("R2 ovf ignores other bits", v, 16'h0010);
    wr(4'd1, 16'h0010);
    rd(4'd1, v); chk("R2 ovf cleared", v, 16'h0);
    chk("R7 irq dropped", {15'h0, irq_o}, 16'h0);
    wr(4'd0, 16'h0000);
  endtask

  task automatic edge0(input logic lvl);
    @(negedge clk_i);
    cex_i[0] = lvl;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    wr(4'd4, 16'h0020);            // rising only
    wr(4'd2, 16'h1234);
    edge0(1'b1);
    rd(4'd8, v); chk("R3 rising capture value", v, 16'h1234);
    rd(4'd1, v); chk("R3 rising capture flag", v, 16'h0001);
    wr(4'd1, 16'h0001);
    wr(4'd2, 16'h5555);
    edge0(1'b0);
    rd(4'd8, v); chk("R3 falling ignored ccr", v, 16'h1234);
    rd(4'd1, v); chk("R3 falling ignored flag", v, 16'h0);
    wr(4'd4, 16'h0010);            // falling only
    wr(4'd2, 16'h2222);
    edge0(1'b1);
    rd(4'd8, v); chk("R3 rising ignored ccr", v, 16'h1234);
    edge0(1'b0);
    rd(4'd8, v); chk("R3 falling capture", v, 16'h2222);
    wr(4'd1, 16'h0001);
    wr(4'd4, 16'h0030);            // both
    wr(4'd2, 16'h3333);
    edge0(1'b1);
    rd(4'd8, v); chk("R3 both rising", v, 16'h3333);
    wr(4'd2, 16'h4444);
    edge0(1'b0);
    rd(4'd8, v); chk("R3 both falling", v, 16'h4444);
    rd(4'd4, v); chk("R9 mode readback", v, 16'h0030);
    wr(4'd4, 16'h0000);
    wr(4'd1, 16'h001F);
  endtask

  task automatic t_match();
    logic [15:0] v;
    wr(4'd9, 16'h0100);  wr(4'd10, 16'h0100); wr(4'd11, 16'h0100);
    wr(4'd5, 16'h000D);                // mat|tog|ecf
    wr(4'd6, 16'h0004);                // tog only
    wr(4'd7, 16'h0008);                // mat only, no irq enable
    wr(4'd2, 16'h00F0);
    wr(4'd0, 16'h0001);
    repeat (4) @(negedge clk_i);
    chk("R5 no toggle before match", {12'h0, cex_o}, 16'h0);
    repeat (40) @(negedge clk_i);
    rd(4'd1, v); chk("R4 flags only with match enable", v, 16'h000A);
    chk("R5 toggled outputs", {12'h0, cex_o}, 16'h0006);
    chk("R7 irq from enabled flag", {15'h0, irq_o}, 16'h1);
    wr(4'd1, 16'h0002);
    rd(4'd1, v); chk("R6 clear one flag", v, 16'h0008);
    chk("R7 masked flag no irq", {15'h0, irq_o}, 16'h0);
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'h001F);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    wr(4'd9, 16'h0200);
    wr(4'd5, 16'h0008);
    wr(4'd6, 16'h0000); wr(4'd7, 16'h0000);
    wr(4'd2, 16'h01F0);
    wr(4'd0, 16'h0001);
    for (int i = 0; i < 40; i++) begin
      rd(4'd2, v);
      if (v == 16'h01FF) break;
      @(negedge clk_i);
    end
    wr(4'd1, 16'h0002);                // lands in the match cycle
    rd(4'd1, v); chk("R6 set wins over clear", v, 16'h0002);
    wr(4'd1, 16'h0002);
    rd(4'd1, v); chk("R6 later clear", v, 16'h0);
    wr(4'd0, 16'h0000);
    wr(4'd5, 16'h0000);
  endtask

  task automatic t_pwm();
    logic [15:0] c;
    logic [7:0]  exp_duty, pending;
    bit          valid;
    int          bad, seen;
    valid = 0; bad = 0; seen = 0; exp_duty = '0;
    wr(4'd4, 16'h0002);
    wr(4'd8, 16'h0040);
    pending = 8'h40;
    wr(4'd2, 16'h00F8);
    wr(4'd0, 16'h0001);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk_i);
      if (i == 300) begin
        bus_we_i = 1'b1; bus_addr_i = 4'd8; bus_wdata_i = 16'h00C0;
        @(posedge clk_i); #0.5;
        bus_we_i = 1'b0;
        pending = 8'hC0;
        continue;
      end
      rd(4'd2, c);
      if (c[7:0] == 8'h00) begin valid = 1; exp_duty = pending; end
      if (valid) begin
        seen++;
        if (cex_o[0] !== (c[7:0] >= exp_duty)) bad++;
      end
    end
    chk("R8 pwm samples seen", 16'(seen > 400), 16'h1);
    chk("R8 pwm output vs duty", 16'(bad), 16'h0);
    wr(4'd0, 16'h0000);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_run();
    t_ovf();
    t_capture();
    t_match();
    t_collide();
    t_pwm();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule